// File: doc/BRIEF.md
# Synthesizer Serial Programming Controller

This block sits on the host side of a frequency synthesizer and programs it over a three-line serial link: a serial clock, a serial data line and a load strobe. Every transfer is a 24-bit word. The two least significant bits of each word form a code that tells the synthesizer which internal latch the word is for. The controller writes those two bits itself, so whatever the caller supplies in bits 1:0 of a configuration word is replaced.

When reset is released, the controller programs all four latches once. It sends the initialization word, then the function word, then the reference word, and last a divider word for channel 0. After that, each channel request produces a single divider word. The controller forms the total division as a base value plus the channel index and splits it for a dual-modulus prescaler: B is the quotient and A is the remainder. A division that cannot be programmed raises an error pulse, and nothing is sent for it.

One request can wait while a transfer is in progress. A newer request replaces the one that is waiting.

Top module: `synth_prog_ctrl`

## Requirements
- R1: Each word carries its latch code in bits 1:0, and the controller forces this code whatever bits 1:0 of the supplied word hold. The codes are: 11 for the initialization word, 10 for the function word, 00 for the reference word and 01 for the divider word.
- R2: After reset, `busy` stays high while exactly four words are sent in this order: initialization, function, reference, then the divider word for channel 0.
- R3: A divider word is built from N = N_BASE + channel. It holds B = N / PRESC in bits 20:8, A = N mod PRESC in bits 7:2, and the `cp_gain` input in bit 21. Bits 23:22 are zero.
- R4: After start-up, a channel request sends exactly one word, the divider word.
- R5: A request with A > B, or with a B that does not fit in 13 bits, produces a one-cycle `err` pulse. No word is sent and no `done` pulse occurs for it.
- R6: Each word is shifted most significant bit first, with exactly 24 rising serial-clock edges. Serial data changes only while the serial clock is low.
- R7: After the 24th bit, the load strobe stays high for at least two serial-clock periods (4·CLK_DIV system cycles), and the serial clock is held low during the strobe.
- R8: The serial clock period is 2·CLK_DIV system clock cycles.
- R9: A request that arrives while the controller is busy is held and served afterwards. If a second request arrives before service, the first one is discarded.
- R10: `done` is a one-cycle pulse, given once when start-up finishes and once per completed channel change. While `busy` is low, the serial clock and the load strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle channel request strobe |
| req_chan | input | CH_W | Channel index of the request |
| cp_gain | input | 1 | Charge-pump gain bit placed in divider words |
| init_word | input | 24 | Initialization latch contents (bits 1:0 replaced) |
| func_word | input | 24 | Function latch contents (bits 1:0 replaced) |
| ref_word | input | 24 | Reference latch contents (bits 1:0 replaced) |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Load strobe |
| busy | output | 1 | High while a sequence runs or a request waits |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a request that cannot be programmed |

## Verification
The divider computation is driven with a set of channels chosen to separate its outcomes:
- the lowest channel;
- the highest channel;
- a channel that yields the known word 0x002741;
- channels where A is zero;
- a channel where A equals B, which is the largest legal remainder;
- channels where A is one more than B, or far above it, which must raise an error.

Toggling the gain bit across these vectors shows that bit 21 follows the input and not the channel. The start-up run uses configuration words whose bits 1:0 are wrong on purpose, which exposes any failure to force the latch codes. Two requests issued during start-up tell holding apart from overwriting.

// File: rtl/synth_prog_pkg.sv
// Package: shared widths, latch codes and state types for the
// synthesizer programming controller.
package synth_prog_pkg;
    localparam int WORD_W = 24;   // bits per serial word
    localparam int A_W    = 6;    // A count field width
    localparam int B_W    = 13;   // B count field width

    // Latch codes carried in bits 1:0 of each word
    localparam logic [1:0] LC_REF  = 2'b00;
    localparam logic [1:0] LC_NDIV = 2'b01;
    localparam logic [1:0] LC_FUNC = 2'b10;
    localparam logic [1:0] LC_INIT = 2'b11;

    typedef enum logic [1:0] {SQ_LOAD, SQ_WAIT, SQ_IDLE} seq_st_t;
    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_STROBE} sh_st_t;
endpackage

// File: rtl/ndiv_calc.sv
// Module: ndiv_calc
// Turns a channel index into the divider word. The total division is
// N = N_BASE + chan, split as B = N / PRESC and A = N mod PRESC.
// Purely combinational. Assumes CH_W is below A_W + B_W.
module ndiv_calc
    import synth_prog_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int N_BASE = 1264,
    parameter int PRESC  = 32
) (
    input  logic [CH_W-1:0]   chan,
    input  logic              gain,
    output logic [WORD_W-1:0] word,
    output logic              bad
);
    localparam int NW = A_W + B_W;

    logic [NW-1:0] n_tot, b_full, a_full;

    // Split the total division into prescaler quotient and remainder
    always_comb begin
        n_tot  = NW'(N_BASE) + NW'(chan);
        b_full = n_tot / NW'(PRESC);
        a_full = n_tot % NW'(PRESC);
        bad    = (a_full > b_full) || ((b_full >> B_W) != '0)
                 || ((a_full >> A_W) != '0);
        word   = {2'b00, gain, b_full[B_W-1:0], a_full[A_W-1:0], LC_NDIV};
    end
endmodule

// File: rtl/req_hold.sv
// Module: req_hold
// One-entry request register. A new request always overwrites the
// entry. A take clears it unless a new request arrives in the same cycle.
module req_hold #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [CH_W-1:0] in_chan,
    input  logic            take,
    output logic            pend_valid,
    output logic [CH_W-1:0] pend_chan
);
    // Store newest request, drop it once taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_chan  <= '0;
        end else if (in_valid) begin
            pend_valid <= 1'b1;
            pend_chan  <= in_chan;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_shifter.sv
// Module: serial_shifter
// Shifts one word out MSB first on a three-line link, then raises the load
// strobe for LE_HALF serial half periods. Data changes together with
// the serial clock falling. Start is accepted only while busy is low.
module serial_shifter
    import synth_prog_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int LE_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              sdata,
    output logic              sle,
    output logic              busy,
    output logic              done
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int LE_W  = $clog2(LE_HALF + 1);

    sh_st_t            st;
    logic [DIV_W-1:0]  divcnt;
    logic [BIT_W-1:0]  bitcnt;
    logic [LE_W-1:0]   lecnt;
    logic [WORD_W-1:0] shreg;
    logic              tick;

    assign tick = (divcnt == DIV_W'(CLK_DIV - 1));
    assign busy = (st != SH_IDLE);

    // Half-period divider, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n || st == SH_IDLE || tick) divcnt <= '0;
        else                                 divcnt <= divcnt + 1'b1;
    end

    // Shift and strobe sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SH_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            lecnt  <= '0;
            sclk   <= 1'b0;
            sdata  <= 1'b0;
            sle    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: if (start) begin
                    shreg  <= word;
                    sdata  <= word[WORD_W-1];
                    bitcnt <= '0;
                    sclk   <= 1'b0;
                    st     <= SH_SHIFT;
                end
                SH_SHIFT: if (tick) begin
                    if (!sclk) begin
                        sclk <= 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        if (bitcnt == BIT_W'(WORD_W - 1)) begin
                            sle   <= 1'b1;
                            lecnt <= '0;
                            st    <= SH_STROBE;
                        end else begin
                            shreg  <= shreg << 1;
                            sdata  <= shreg[WORD_W-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                SH_STROBE: if (tick) begin
                    if (lecnt == LE_W'(LE_HALF - 1)) begin
                        sle  <= 1'b0;
                        done <= 1'b1;
                        st   <= SH_IDLE;
                    end else begin
                        lecnt <= lecnt + 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/synth_prog_ctrl.sv
// Module: synth_prog_ctrl (top)
// Sequences the start-up write of all four latches, then serves channel
// requests by sending divider words only. Assumes the configuration
// inputs are held stable while busy is high.
module synth_prog_ctrl
    import synth_prog_pkg::*;
#(
    parameter int CH_W    = 8,
    parameter int N_BASE  = 1264,
    parameter int PRESC   = 32,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              cp_gain,
    input  logic [WORD_W-1:0] init_word,
    input  logic [WORD_W-1:0] func_word,
    input  logic [WORD_W-1:0] ref_word,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int LE_HALF = 4;              // two full serial periods
    localparam logic [1:0] LAST_STEP = 2'd3;

    seq_st_t           st;
    logic [1:0]        step;
    logic              boot;
    logic [CH_W-1:0]   run_chan, pend_chan, calc_chan;
    logic              pend_valid, take;
    logic [WORD_W-1:0] n_word, tx_word;
    logic              n_bad, sh_busy, sh_done;

    assign take = (st == SQ_IDLE) && pend_valid;
    assign busy = (st != SQ_IDLE) || pend_valid;

    req_hold #(.CH_W(CH_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_chan(req_chan),
        .take(take), .pend_valid(pend_valid), .pend_chan(pend_chan)
    );

    // Channel under computation: waiting request when idle, else running one
    always_comb begin
        if (st == SQ_IDLE) calc_chan = pend_chan;
        else if (boot)     calc_chan = '0;
        else               calc_chan = run_chan;
    end

    ndiv_calc #(.CH_W(CH_W), .N_BASE(N_BASE), .PRESC(PRESC)) u_calc (
        .chan(calc_chan), .gain(cp_gain), .word(n_word), .bad(n_bad)
    );

    // Word selection with forced latch code
    always_comb begin
        tx_word = n_word;
        if (boot) begin
            case (step)
                2'd0:    tx_word = (init_word & ~WORD_W'(3)) | WORD_W'(LC_INIT);
                2'd1:    tx_word = (func_word & ~WORD_W'(3)) | WORD_W'(LC_FUNC);
                2'd2:    tx_word = (ref_word  & ~WORD_W'(3)) | WORD_W'(LC_REF);
                default: tx_word = n_word;
            endcase
        end
    end

    serial_shifter #(.CLK_DIV(CLK_DIV), .LE_HALF(LE_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(st == SQ_LOAD), .word(tx_word),
        .sclk(ser_clk), .sdata(ser_data), .sle(ser_le),
        .busy(sh_busy), .done(sh_done)
    );

    // Sequencer: start-up steps, then request service
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_LOAD;
            step     <= '0;
            boot     <= 1'b1;
            run_chan <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (st)
                SQ_LOAD: if (!sh_busy) st <= SQ_WAIT;
                SQ_WAIT: if (sh_done) begin
                    if (boot && step != LAST_STEP) begin
                        step <= step + 1'b1;
                        st   <= SQ_LOAD;
                    end else begin
                        boot <= 1'b0;
                        done <= 1'b1;
                        st   <= SQ_IDLE;
                    end
                end
                SQ_IDLE: if (pend_valid) begin
                    if (n_bad) begin
                        err <= 1'b1;
                    end else begin
                        run_chan <= pend_chan;
                        st       <= SQ_LOAD;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/synth_prog_chk.sv
// Module: synth_prog_chk
// Protocol checker bound to synth_prog_ctrl. Observes the ports only.
module synth_prog_chk #(
    parameter int CLK_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_le,
    input logic busy,
    input logic done,
    input logic err
);
    logic [5:0]  rise_cnt;
    logic [15:0] le_cnt;
    logic        clk_q;

    // Count serial clock rises since the last strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            clk_q    <= 1'b0;
        end else begin
            clk_q <= ser_clk;
            if (ser_le)                rise_cnt <= '0;
            else if (ser_clk && !clk_q) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // Count cycles the strobe has been high
    always_ff @(posedge clk) begin
        if (!rst_n || !ser_le) le_cnt <= '0;
        else                   le_cnt <= le_cnt + 1'b1;
    end

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
    // R6
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_le) |-> (rise_cnt == 6'd24));
    // R7
    le_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_le) |-> (le_cnt >= 16'(4 * CLK_DIV)));
    // R7
    clk_low_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le |-> !ser_clk);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_le && !ser_clk));
    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

bind synth_prog_ctrl synth_prog_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .busy(busy), .done(done), .err(err)
);

// File: tb/synth_prog_ctrl_test.sv
// Bench for synth_prog_ctrl: a serial receiver model, a vector table of
// channel requests, and directed start-up / overwrite / timing tests.
module synth_prog_ctrl_test;
    localparam int CH_W    = 11;
    localparam int N_BASE  = 64;
    localparam int CLK_DIV = 2;

    typedef struct packed {
        logic [10:0] ch;
        logic        g;
        logic [23:0] w;
        logic        e;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{11'd1200, 1'b0, 24'h002741, 1'b0},
        '{11'd0,    1'b1, 24'h200201, 1'b0},
        '{11'd31,   1'b0, 24'h000000, 1'b1},
        '{11'd3,    1'b0, 24'h000000, 1'b1},
        '{11'd2,    1'b0, 24'h000209, 1'b0},
        '{11'd2047, 1'b1, 24'h20417D, 1'b0},
        '{11'd100,  1'b0, 24'h000511, 1'b0},
        '{11'd96,   1'b1, 24'h200501, 1'b0},
        '{11'd101,  1'b0, 24'h000515, 1'b0},
        '{11'd102,  1'b0, 24'h000000, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [CH_W-1:0] req_chan = '0;
    logic            cp_gain = 1'b0;
    logic [23:0]     init_word = 24'h9F8080;
    logic [23:0]     func_word = 24'h9F8081;
    logic [23:0]     ref_word  = 24'h000013;
    logic            ser_clk, ser_data, ser_le, busy, done, err;

    int n_checks = 0, n_fail = 0;
    int rx_cnt = 0, rx_bits = 0, bad_bits = 0;
    int done_cnt = 0, err_cnt = 0, le_len = 0, le_min = 1000;
    logic [23:0] rx_sh = '0;
    logic [23:0] rx_log [16];
    time last_rise = 0, period = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    synth_prog_ctrl #(.CH_W(CH_W), .N_BASE(N_BASE), .PRESC(32),
                      .CLK_DIV(CLK_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .cp_gain(cp_gain), .init_word(init_word), .func_word(func_word),
        .ref_word(ref_word), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .busy(busy), .done(done), .err(err)
    );

    // Receiver model: sample on rising serial clock, latch on strobe
    always @(posedge ser_clk) begin
        rx_sh = {rx_sh[22:0], ser_data};
        rx_bits++;
        if (rx_bits == 2) period = $time - last_rise;
        last_rise = $time;
    end
    always @(posedge ser_le) begin
        if (rx_bits != 24) bad_bits++;
        rx_bits = 0;
        if (rx_cnt < 16) rx_log[rx_cnt] = rx_sh;
        rx_cnt++;
    end

    // Pulse and strobe width monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (err)  err_cnt++;
        if (ser_le) le_len++;
        else begin
            if (le_len != 0 && le_len < le_min) le_min = le_len;
            le_len = 0;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_req(input logic [CH_W-1:0] ch);
        @(negedge clk);
        req_valid = 1'b1;
        req_chan  = ch;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int rx0, d0, e0;
        // Reset state
        repeat (4) @(negedge clk);
        chk(!ser_clk && !ser_le && !done && !err, "reset R10",
            {ser_clk, ser_le, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: busy during start-up
        chk(busy == 1'b1, "R2 busy at start", busy, 1);
        // R9: two requests during start-up, newer must win
        repeat (30) @(negedge clk);
        send_req(11'd1200);
        repeat (5) @(negedge clk);
        send_req(11'd96);
        wait_idle();
        chk(rx_cnt == 5, "R9 word count after start-up", rx_cnt, 5);
        // R1/R2: order and codes of start-up words
        chk(rx_log[0] == 24'h9F8083, "R1 R2 init word", rx_log[0], 24'h9F8083);
        chk(rx_log[1] == 24'h9F8082, "R1 R2 func word", rx_log[1], 24'h9F8082);
        chk(rx_log[2] == 24'h000010, "R1 R2 ref word", rx_log[2], 24'h000010);
        chk(rx_log[3] == 24'h000201, "R2 R3 channel 0 word", rx_log[3], 24'h000201);
        chk(rx_log[4] == 24'h000501, "R9 newest request kept", rx_log[4], 24'h000501);
        chk(done_cnt == 2, "R10 done pulses", done_cnt, 2);
        // R8: serial clock period
        chk(period == time'(2 * CLK_DIV * 4), "R8 sclk period", period, 2 * CLK_DIV * 4);

        // Vector table walk: R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            rx0 = rx_cnt; d0 = done_cnt; e0 = err_cnt;
            cp_gain = VECS[i].g;
            send_req(VECS[i].ch);
            wait_idle();
            if (VECS[i].e) begin
                chk(err_cnt == e0 + 1, "R5 err pulse", err_cnt - e0, 1);
                chk(rx_cnt == rx0 && done_cnt == d0, "R5 nothing sent",
                    rx_cnt - rx0, 0);
            end else begin
                chk(rx_cnt == rx0 + 1, "R4 one word per change", rx_cnt - rx0, 1);
                chk(rx_log[rx0 % 16] == VECS[i].w, "R3 divider word",
                    rx_log[rx0 % 16], VECS[i].w);
                chk(done_cnt == d0 + 1 && err_cnt == e0, "R10 done per change",
                    done_cnt - d0, 1);
            end
        end

        // R6 / R7 timing observed over all words
        chk(bad_bits == 0, "R6 bits per word", bad_bits, 0);
        chk(le_min >= 4 * CLK_DIV, "R7 strobe width", le_min, 4 * CLK_DIV);
        chk(!busy && !ser_clk && !ser_le, "R10 idle lines",
            {busy, ser_clk, ser_le}, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule